// File: doc/BRIEF.md
# Mirrored List Status and Interrupt Aggregator

This block keeps, for each of a parameterized number of processing lists, one sticky interrupt flag, one trigger-enable bit and one trigger-source selection. It also contains a periodic trigger timer. Every flag and every enable is a single storage element that two register addresses can reach. One address is the list's own register. The other is a common register that gathers the same bit for all lists. Software can clear a flag, or set or change an enable, through either address, and both addresses always read back the same state.

A hardware pulse on a list's interrupt input sets that list's flag. The flag then stays set until software writes a 1 to one of its two locations. The common interrupt output is high while any flag is set. Each list picks its trigger from a vector of external trigger sources using a 5-bit code. Code 7 is replaced by the internal timer's pulse. The chosen trigger reaches the list's output only while the list's enable is set.

With the default of 4 lists the register map is as follows. Addresses 0 to 3 are the list control registers: enable in bit 15, source code in bits 4:0. Addresses 4 to 7 are the list status registers, with the flag in bit 0. Address 8 is the common enable register, address 9 is the common flag register, and address 10 holds the 16-bit timer period. In general the status registers start at N, and the common registers sit at 2N, 2N+1 and 2N+2.

Top module: `list_irq_hub`

## Requirements
- R1: After reset all flags, enables, source codes and the timer period are 0, `irq_o` is 0 and every `list_trig_o` bit is 0.
- R2: A one-cycle pulse on `list_irq_i[i]` sets flag i, which is visible from the next cycle. The flag stays set without further pulses until software clears it.
- R3: Writing a 1 to bit 0 of list status register N+i clears flag i. Writing 0 there leaves the flag unchanged.
- R4: Writing the common flag register (2N+1) clears every flag whose bit in the written data is 1 and leaves the other flags unchanged. Reading that register returns flag i in bit i.
- R5: If a hardware set and a software clear of the same flag occur in the same cycle, the flag is set afterwards.
- R6: `irq_o` is 1 in every cycle in which at least one flag is set and 0 when none is set. It rises in the cycle after the pulse that sets the first flag.
- R7: List control register i holds enable i in bit 15. The common enable register (2N) holds enable i in bit i. A write to either one changes the same bit, and both views read back equal values. A write to the common register leaves the source codes untouched.
- R8: The source code in bits 4:0 of list control register i selects bit `trig_src_i[code]` combinationally onto `list_trig_o[i]` while enable i is 1. `list_trig_o[i]` is 0 while enable i is 0.
- R9: Source code 7 routes the timer pulse instead of `trig_src_i[7]`.
- R10: With a nonzero period P written to address 2N+2, the timer emits a one-cycle pulse every P+1 cycles. The first pulse comes P cycles after the write takes effect. A period of 0 holds the timer stopped with no pulses.
- R11: `rdata_o` follows `addr_i` combinationally. Unused bits read as 0. Addresses above 2N+2 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address for reads and writes |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| list_irq_i | input | NUM_LISTS | Per-list hardware interrupt pulses |
| trig_src_i | input | 32 | External trigger sources, indexed by source code |
| list_trig_o | output | NUM_LISTS | Gated trigger for each list |
| irq_o | output | 1 | Common interrupt |

## Verification
Flags are set by single pulses on one list and on several lists, and are cleared through the list view and through the common view. This separates a per-bit clear from one that disturbs neighbouring lists, and it catches a clear that reaches only one of the two views. A set pulse that lands in the same cycle as a clear shows which of the two wins. Enables are written through each view and read back through the other. Trigger outputs are driven with the source high and then low, with the list enabled and then disabled, and with code 7 while `trig_src_i[7]` is held high, so that timer routing cannot be confused with the plain source bit. The timer runs with a small period, where the pulse positions are counted, and with period 0, which must give no pulses at all.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam int unsigned DATA_W   = 16;
    localparam int unsigned EN_BIT   = 15;
    localparam int unsigned SRC_W    = 5;
    localparam int unsigned NUM_SRC  = 1 << SRC_W;
    localparam int unsigned TMR_SRC  = 7;
    localparam int unsigned PERIOD_W = 16;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NUM_LISTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LISTS-1:0] set_i,
    input  logic [NUM_LISTS-1:0] clr_i,
    output logic [NUM_LISTS-1:0] flags_o,
    output logic                 irq_o
);
    typedef struct packed {
        logic [NUM_LISTS-1:0] flags;
    } flag_state_t;

    flag_state_t state_d, state_q;

    always_comb begin
        state_d       = state_q;
        // hardware set has priority over a software clear
        state_d.flags = (state_q.flags & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign flags_o = state_q.flags;
    assign irq_o   = |state_q.flags;

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> irq_o);

    for (genvar i = 0; i < NUM_LISTS; i++) begin : g_chk
        // R2 R5
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flags_o[i]);
        // R2
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[i] && !clr_i[i]) |=> flags_o[i]);
        // R3 R4
        flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !flags_o[i]);
    end
endmodule

// File: rtl/irq_ctrl_bank.sv
module irq_ctrl_bank
    import irq_hub_pkg::*;
#(
    parameter int NUM_LISTS = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_LISTS-1:0]            wr_list_i,
    input  logic                            wr_cmn_i,
    input  logic                            wen_bit_i,
    input  logic [SRC_W-1:0]                wsel_i,
    input  logic [NUM_LISTS-1:0]            wmask_i,
    output logic [NUM_LISTS-1:0]            en_o,
    output logic [NUM_LISTS-1:0][SRC_W-1:0] sel_o
);
    typedef struct packed {
        logic [NUM_LISTS-1:0]            en;
        logic [NUM_LISTS-1:0][SRC_W-1:0] sel;
    } ctrl_state_t;

    ctrl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_LISTS; i++) begin
            if (wr_list_i[i]) begin
                state_d.en[i]  = wen_bit_i;
                state_d.sel[i] = wsel_i;
            end
        end
        if (wr_cmn_i) state_d.en = wmask_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign en_o  = state_q.en;
    assign sel_o = state_q.sel;

    // R7
    cmn_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmn_i |=> (en_o == $past(wmask_i)));
    // R7
    cmn_sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmn_i && wr_list_i == '0) |=> $stable(sel_o));

    for (genvar i = 0; i < NUM_LISTS; i++) begin : g_chk
        // R7
        list_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_list_i[i] && !wr_cmn_i) |=> (en_o[i] == $past(wen_bit_i)));
    end
endmodule

// File: rtl/irq_period_timer.sv
module irq_period_timer
    import irq_hub_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [PERIOD_W-1:0] wdata_i,
    output logic [PERIOD_W-1:0] period_o,
    output logic                tick_o
);
    typedef struct packed {
        logic [PERIOD_W-1:0] period;
        logic [PERIOD_W-1:0] count;
    } tmr_state_t;

    tmr_state_t state_d, state_q;
    logic       at_end;

    assign at_end = (state_q.period != '0) && (state_q.count >= state_q.period);

    always_comb begin
        state_d = state_q;
        if (wr_i) state_d.period = wdata_i;
        if (state_q.period == '0 || at_end) state_d.count = '0;
        else                                state_d.count = state_q.count + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign tick_o   = at_end;
    assign period_o = state_q.period;

    // R10
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    // R10
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (state_q.count == '0));
endmodule

// File: rtl/irq_trig_mux.sv
module irq_trig_mux
    import irq_hub_pkg::*;
#(
    parameter int NUM_LISTS = 4
) (
    input  logic [NUM_SRC-1:0]              src_i,
    input  logic                            tick_i,
    input  logic [NUM_LISTS-1:0]            en_i,
    input  logic [NUM_LISTS-1:0][SRC_W-1:0] sel_i,
    output logic [NUM_LISTS-1:0]            trig_o
);
    logic [NUM_SRC-1:0] src_vec;

    always_comb begin
        src_vec          = src_i;
        src_vec[TMR_SRC] = tick_i;
    end

    for (genvar i = 0; i < NUM_LISTS; i++) begin : g_list
        assign trig_o[i] = en_i[i] & src_vec[sel_i[i]];
    end
endmodule

// File: rtl/list_irq_hub.sv
module list_irq_hub
    import irq_hub_pkg::*;
#(
    parameter  int NUM_LISTS = 4,
    localparam int ADDR_W    = $clog2(2 * NUM_LISTS + 3)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    input  logic [NUM_LISTS-1:0] list_irq_i,
    input  logic [NUM_SRC-1:0]   trig_src_i,
    output logic [NUM_LISTS-1:0] list_trig_o,
    output logic                 irq_o
);
    localparam logic [ADDR_W-1:0] A_CMN_EN   = ADDR_W'(2 * NUM_LISTS);
    localparam logic [ADDR_W-1:0] A_CMN_FLAG = ADDR_W'(2 * NUM_LISTS + 1);
    localparam logic [ADDR_W-1:0] A_PERIOD   = ADDR_W'(2 * NUM_LISTS + 2);

    logic [NUM_LISTS-1:0]            wr_list, clr_vec, flags, en;
    logic [NUM_LISTS-1:0][SRC_W-1:0] sel;
    logic                            wr_cmn_en, wr_period, tick;
    logic [PERIOD_W-1:0]             period;

    // write decode: list view and common view both feed the same storage
    always_comb begin
        wr_list = '0;
        clr_vec = '0;
        for (int i = 0; i < NUM_LISTS; i++) begin
            if (wr_en_i && addr_i == ADDR_W'(i))             wr_list[i] = 1'b1;
            if (wr_en_i && addr_i == ADDR_W'(NUM_LISTS + i)) clr_vec[i] = wdata_i[0];
            if (wr_en_i && addr_i == A_CMN_FLAG)             clr_vec[i] = clr_vec[i] | wdata_i[i];
        end
    end

    assign wr_cmn_en = wr_en_i && (addr_i == A_CMN_EN);
    assign wr_period = wr_en_i && (addr_i == A_PERIOD);

    irq_flag_bank #(.NUM_LISTS(NUM_LISTS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (list_irq_i),
        .clr_i   (clr_vec),
        .flags_o (flags),
        .irq_o   (irq_o)
    );

    irq_ctrl_bank #(.NUM_LISTS(NUM_LISTS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_list_i (wr_list),
        .wr_cmn_i  (wr_cmn_en),
        .wen_bit_i (wdata_i[EN_BIT]),
        .wsel_i    (wdata_i[SRC_W-1:0]),
        .wmask_i   (wdata_i[NUM_LISTS-1:0]),
        .en_o      (en),
        .sel_o     (sel)
    );

    irq_period_timer u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_period),
        .wdata_i  (wdata_i[PERIOD_W-1:0]),
        .period_o (period),
        .tick_o   (tick)
    );

    irq_trig_mux #(.NUM_LISTS(NUM_LISTS)) u_mux (
        .src_i  (trig_src_i),
        .tick_i (tick),
        .en_i   (en),
        .sel_i  (sel),
        .trig_o (list_trig_o)
    );

    // read mux
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_LISTS; i++) begin
            if (addr_i == ADDR_W'(i)) begin
                rdata_o[EN_BIT]      = en[i];
                rdata_o[SRC_W-1:0]   = sel[i];
            end
            if (addr_i == ADDR_W'(NUM_LISTS + i)) rdata_o[0] = flags[i];
        end
        if (addr_i == A_CMN_EN)   rdata_o[NUM_LISTS-1:0] = en;
        if (addr_i == A_CMN_FLAG) rdata_o[NUM_LISTS-1:0] = flags;
        if (addr_i == A_PERIOD)   rdata_o[PERIOD_W-1:0]  = period;
    end

    // R6
    irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && list_irq_i == '0) |=> !irq_o);
    // R11
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i > A_PERIOD) |=> ($stable(flags) || $past(list_irq_i) != '0));

    for (genvar i = 0; i < NUM_LISTS; i++) begin : g_chk
        // R8
        gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            list_trig_o[i] |-> en[i]);
    end
endmodule

// File: tb/tb_list_irq_hub.sv
module tb_list_irq_hub;
    localparam int N  = 4;
    localparam int AW = $clog2(2 * N + 3);

    logic          clk = 0;
    logic          rst_n = 0;
    logic          wr_en_i = 0;
    logic [AW-1:0] addr_i = '0;
    logic [15:0]   wdata_i = '0;
    logic [15:0]   rdata_o;
    logic [N-1:0]  list_irq_i = '0;
    logic [31:0]   trig_src_i = '0;
    logic [N-1:0]  list_trig_o;
    logic          irq_o;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    list_irq_hub #(.NUM_LISTS(N)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .list_irq_i(list_irq_i),
        .trig_src_i(trig_src_i), .list_trig_o(list_trig_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en_i = 1; addr_i = AW'(a); wdata_i = d;
        @(negedge clk);
        wr_en_i = 0; wdata_i = '0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        @(negedge clk);
        addr_i = AW'(a);
        #1 d = rdata_o;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        @(negedge clk);
        list_irq_i = m;
        @(negedge clk);
        list_irq_i = '0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R1 irq_o", irq_o, 0);
        chk("R1 trig", list_trig_o, 0);
        rd(9, d);  chk("R1 flags", d, 0);
        rd(8, d);  chk("R1 enables", d, 0);
        rd(2, d);  chk("R1 ctrl2", d, 0);
        rd(10, d); chk("R1 period", d, 0);
    endtask

    task automatic t_sticky();
        logic [15:0] d;
        pulse(4'b0100);
        #1 chk("R6 irq after set", irq_o, 1);
        repeat (5) @(negedge clk);
        rd(6, d); chk("R2 sticky flag2", d, 1);
        rd(5, d); chk("R2 other flag untouched", d, 0);
        wr(6, 16'h0000);
        rd(6, d); chk("R3 write 0 keeps", d, 1);
        wr(6, 16'h0001);
        rd(6, d); chk("R3 list clear", d, 0);
        rd(9, d); chk("R4 common view after list clear", d, 0);
        #1 chk("R6 irq low when none", irq_o, 0);
    endtask

    task automatic t_cmn_clear();
        logic [15:0] d;
        pulse(4'b1011);
        rd(9, d); chk("R4 common read", d, 16'h000b);
        wr(9, 16'h0009);
        rd(9, d); chk("R4 common clear partial", d, 16'h0002);
        rd(5, d); chk("R4 list view remains", d, 1);
        #1 chk("R6 irq still high", irq_o, 1);
        wr(5, 16'h0001);
        #1 chk("R6 irq low", irq_o, 0);
    endtask

    task automatic t_set_wins();
        logic [15:0] d;
        @(negedge clk);
        list_irq_i = 4'b0010; wr_en_i = 1; addr_i = AW'(5); wdata_i = 16'h0001;
        @(negedge clk);
        list_irq_i = '0; wr_en_i = 0; wdata_i = '0;
        rd(5, d); chk("R5 set wins list clear", d, 1);
        @(negedge clk);
        list_irq_i = 4'b0010; wr_en_i = 1; addr_i = AW'(9); wdata_i = 16'h000f;
        @(negedge clk);
        list_irq_i = '0; wr_en_i = 0; wdata_i = '0;
        rd(9, d); chk("R5 set wins common clear", d, 16'h0002);
        wr(9, 16'h000f);
        rd(9, d); chk("R4 clear all", d, 0);
    endtask

    task automatic t_enable_mirror();
        logic [15:0] d;
        wr(1, 16'h8003);
        rd(8, d); chk("R7 list write seen in common", d, 16'h0002);
        rd(1, d); chk("R7 list ctrl readback", d, 16'h8003);
        wr(8, 16'h0005);
        rd(1, d); chk("R7 common disable keeps code", d, 16'h0003);
        rd(0, d); chk("R7 common enable list0", d, 16'h8000);
        rd(2, d); chk("R7 common enable list2", d, 16'h8000);
        wr(8, 16'h0000);
    endtask

    task automatic t_trig_select();
        wr(2, 16'h8003);
        @(negedge clk); trig_src_i = 32'h0000_0008;
        #1 chk("R8 selected source high", list_trig_o, 4'b0100);
        trig_src_i = 32'hffff_fff7;
        #1 chk("R8 selected source low", list_trig_o, 4'b0000);
        trig_src_i = 32'h0000_0008;
        wr(8, 16'h0000);
        #1 chk("R8 disabled blocks source", list_trig_o, 4'b0000);
        trig_src_i = '0;
    endtask

    task automatic t_timer();
        int hits;
        int first;
        trig_src_i = 32'h0000_0080;
        wr(0, 16'h8007);
        repeat (3) @(negedge clk);
        chk("R9 code 7 ignores external bit 7", list_trig_o[0], 0);
        wr(10, 16'd3);
        hits = 0; first = -1;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (list_trig_o[0]) begin
                hits++;
                if (first < 0) first = k;
            end
        end
        chk("R10 pulse count period 3", hits, 4);
        chk("R10 first pulse position", first, 2);
        wr(10, 16'd0);
        hits = 0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (list_trig_o[0]) hits++;
        end
        chk("R10 period 0 stops R9", hits, 0);
        trig_src_i = '0;
        wr(0, 16'h0000);
    endtask

    task automatic t_unmapped();
        logic [15:0] d;
        wr(1, 16'h8004);
        wr(10, 16'h0123);
        wr(12, 16'hffff);
        wr(15, 16'hffff);
        rd(12, d); chk("R11 unmapped reads 0", d, 0);
        rd(1, d);  chk("R11 ctrl unchanged", d, 16'h8004);
        rd(10, d); chk("R11 period unchanged", d, 16'h0123);
        rd(9, d);  chk("R11 flags unchanged", d, 0);
        rd(8, d);  chk("R11 enables unchanged", d, 16'h0002);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_sticky();
        t_cmn_clear();
        t_set_wins();
        t_enable_mirror();
        t_trig_select();
        t_timer();
        t_unmapped();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule